// File: doc/BRIEF.md
# Power domain sequencer with interconnect idle handshake

This block switches a small group of power domains on and off under software control. Software writes a power-control word, in which a set bit asks for the domain to be off, and an idle-request word for the domains that can only be idled. The block owns the ordering of every transition. Before a domain's power switch opens, the domain is fenced off at the interconnect through a request/acknowledge handshake. After the switch closes, the fence is released. The point where the reported status flips is set by two programmable transition counts, one for power-down and one for power-up.

Only one domain moves at a time. When several domains disagree with their requested state, they are served in ascending index order. If a handshake stalls, a timeout drops the sequence and sets a sticky per-domain error bit. While that bit is set, the domain is left alone.

The bus-side idle logic is outside the block. It is reached through three per-domain ports: an idle request driven by the block, and an acknowledge and an idle status returned to it. Register reads are combinational from the word address. Writes take effect at the clock edge where `reg_we` is high.

Top module: `pwr_dom_seq`

Word addresses: 0 power control, 1 idle request, 2 status, 3 idle/ack view, 4 separate ack view, 5 power-down count, 6 power-up count, 7 error.

## Requirements
- R1: After reset all domains read as on (status 0), all switches are closed, all idle requests are low, both transition counts read 24 and the error word is 0.
- R2: In the power-control word (address 0), bit i = 1 requests domain i off and 0 requests it on. In the status word (address 2), bit i = 1 means off and 0 means on. After a sequence completes, the status bit equals the requested bit.
- R3: Power-down order: the idle request rises first. The switch output (`pwr_sw_off`, 1 = open) rises only after both acknowledge and idle status have been seen high for that domain.
- R4: The status bit flips exactly N cycles after the switch output changes. N is the power-down count (address 5) when opening and the power-up count (address 6) when closing. A count of 0 behaves as 1.
- R5: Power-up order: the switch closes first and the status shows on. Only in the next cycle does the idle request fall. The sequence ends when acknowledge and idle status are both low.
- R6: Domains flagged by `IDLE_ONLY` have no power bit. For these domains, power-control writes are ignored and read back as 0, and the switch stays closed. The idle-request word (address 1) drives their handshake, and their status bit reads the live idle status. Idle-request bits of the other domains are ignored.
- R7: With `ACK_SPLIT` = 0, address 3 returns idle status in bits [NDOM-1:0] and acknowledge in bits [16+NDOM-1:16]. With `ACK_SPLIT` = 1, address 3 returns idle status only, and address 4 returns acknowledge at the same bit index.
- R8: A write that leaves a domain's requested state equal to its current state starts no sequence. The request, switch and status outputs stay unchanged.
- R9: If acknowledge or idle status does not reach its expected value within `TMO_CYC` cycles, the domain's bit in the error word (address 7) is set. A pending idle request of a power-down is withdrawn, and power is left unchanged. While the error bit is set, the domain is not sequenced. Writing 1 to the error bit clears it.
- R10: At most one domain is between switch actuation and status update. Domains pending at the same time are served lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pwr_sw_off | output | NDOM | Power switch control per domain, 1 = open (off) |
| idle_req | output | NDOM | Interconnect idle request per domain |
| idle_ack | input | NDOM | Interconnect idle acknowledge per domain |
| idle_sts | input | NDOM | Domain idle status per domain |

## Verification
The in-RTL assertions check the following on every cycle:
- A switch never opens unless the request, acknowledge and idle of that domain were all high in the cycle before.
- A power domain's request never falls while it is still off or its switch is open.
- No more than one domain sits between switch and status.
- When an error bit rises, power is left unchanged.

The bench scenarios show the rest:
- the order of events across several domains;
- the exact cycle distance between switch and status for different programmed counts, including zero;
- the lowest-index-first service order;
- that redundant writes and writes to idle-only power bits produce no event;
- the register layout of the acknowledge view;
- that an errored domain stays quiet until its bit is cleared.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_DN_ACK = 3'd1,
        S_DN_IDL = 3'd2,
        S_DN_SW  = 3'd3,
        S_UP_SW  = 3'd4,
        S_UP_REL = 3'd5,
        S_UP_ACK = 3'd6,
        S_UP_IDL = 3'd7
    } seq_st_e;

    localparam logic [2:0] A_PWR   = 3'd0;
    localparam logic [2:0] A_IREQ  = 3'd1;
    localparam logic [2:0] A_STAT  = 3'd2;
    localparam logic [2:0] A_IDLE  = 3'd3;
    localparam logic [2:0] A_ACK   = 3'd4;
    localparam logic [2:0] A_DNCNT = 3'd5;
    localparam logic [2:0] A_UPCNT = 3'd6;
    localparam logic [2:0] A_ERR   = 3'd7;

endpackage

// File: rtl/pds_arb.sv
module pds_arb #(
    parameter int NDOM = 4,
    parameter int IW   = 2
) (
    input  logic [NDOM-1:0] pend_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o
);

    // lowest pending index wins
    always_comb begin
        any_o = |pend_i;
        idx_o = '0;
        for (int i = NDOM - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/pds_regs.sv
module pds_regs
    import pds_pkg::*;
#(
    parameter int              NDOM      = 4,
    parameter logic [NDOM-1:0] IDLE_ONLY = '0,
    parameter int              ACK_SPLIT = 0,
    parameter int              CNT_W     = 16,
    parameter int              DEF_CNT   = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [2:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic [NDOM-1:0]  off_i,
    input  logic [NDOM-1:0]  ack_i,
    input  logic [NDOM-1:0]  idle_i,
    input  logic [NDOM-1:0]  err_set_i,
    output logic [NDOM-1:0]  pwr_o,
    output logic [NDOM-1:0]  ireq_o,
    output logic [CNT_W-1:0] dn_lim_o,
    output logic [CNT_W-1:0] up_lim_o,
    output logic [NDOM-1:0]  err_o
);

    localparam logic [NDOM-1:0] PWR_MASK = ~IDLE_ONLY;

    typedef struct packed {
        logic [NDOM-1:0]  pwr;
        logic [NDOM-1:0]  ireq;
        logic [CNT_W-1:0] dn;
        logic [CNT_W-1:0] up;
        logic [NDOM-1:0]  err;
    } regs_t;

    regs_t q, d;
    logic [31:0] idle_word, ack_word, stat_word;

    always_comb begin
        d = q;
        if (we_i) begin
            case (addr_i)
                A_PWR:   d.pwr  = wdata_i[NDOM-1:0] & PWR_MASK;
                A_IREQ:  d.ireq = wdata_i[NDOM-1:0] & IDLE_ONLY;
                A_DNCNT: d.dn   = wdata_i[CNT_W-1:0];
                A_UPCNT: d.up   = wdata_i[CNT_W-1:0];
                A_ERR:   d.err  = q.err & ~wdata_i[NDOM-1:0];
                default: ;
            endcase
        end
        d.err = d.err | err_set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pwr  <= '0;
            q.ireq <= '0;
            q.dn   <= CNT_W'(DEF_CNT);
            q.up   <= CNT_W'(DEF_CNT);
            q.err  <= '0;
        end else begin
            q <= d;
        end
    end

    generate
        if (ACK_SPLIT == 0) begin : g_shared
            assign idle_word = 32'(idle_i) | (32'(ack_i) << 16);
            assign ack_word  = '0;
        end else begin : g_split
            assign idle_word = 32'(idle_i);
            assign ack_word  = 32'(ack_i);
        end
    endgenerate

    assign stat_word = 32'((off_i & PWR_MASK) | (idle_i & IDLE_ONLY));

    always_comb begin
        case (addr_i)
            A_PWR:   rdata_o = 32'(q.pwr);
            A_IREQ:  rdata_o = 32'(q.ireq);
            A_STAT:  rdata_o = stat_word;
            A_IDLE:  rdata_o = idle_word;
            A_ACK:   rdata_o = ack_word;
            A_DNCNT: rdata_o = 32'(q.dn);
            A_UPCNT: rdata_o = 32'(q.up);
            default: rdata_o = 32'(q.err);
        endcase
    end

    assign pwr_o    = q.pwr;
    assign ireq_o   = q.ireq;
    assign dn_lim_o = q.dn;
    assign up_lim_o = q.up;
    assign err_o    = q.err;

    // R4: counts only change through their own address
    a_r4_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && (addr_i == A_DNCNT || addr_i == A_UPCNT)) |=> ($stable(q.dn) && $stable(q.up)));

endmodule

// File: rtl/pds_seq.sv
module pds_seq
    import pds_pkg::*;
#(
    parameter int              NDOM      = 4,
    parameter logic [NDOM-1:0] IDLE_ONLY = '0,
    parameter int              CNT_W     = 16,
    parameter int              TMO_CYC   = 64,
    parameter int              IW        = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [IW-1:0]    start_idx_i,
    input  logic             goal_off_i,
    input  logic [CNT_W-1:0] dn_lim_i,
    input  logic [CNT_W-1:0] up_lim_i,
    input  logic [NDOM-1:0]  ack_i,
    input  logic [NDOM-1:0]  idle_i,
    output logic             busy_o,
    output logic [NDOM-1:0]  off_o,
    output logic [NDOM-1:0]  req_o,
    output logic [NDOM-1:0]  sw_o,
    output logic [NDOM-1:0]  err_set_o
);

    localparam int TMO_W = $clog2(TMO_CYC + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [IW-1:0]    idx;
        logic [CNT_W-1:0] cnt;
        logic [TMO_W-1:0] tmo;
        logic [NDOM-1:0]  off;
        logic [NDOM-1:0]  req;
        logic [NDOM-1:0]  sw;
    } seq_t;

    seq_t q, d;
    logic             only_k, ack_k, idl_k, tmo_hit, sw_done;
    logic [CNT_W:0]   lim, nxt;

    always_comb begin
        d         = q;
        err_set_o = '0;
        only_k    = IDLE_ONLY[q.idx];
        ack_k     = ack_i[q.idx];
        idl_k     = idle_i[q.idx];
        tmo_hit   = (q.tmo >= TMO_W'(TMO_CYC - 1));
        lim       = {1'b0, (q.st == S_DN_SW) ? dn_lim_i : up_lim_i};
        nxt       = {1'b0, q.cnt} + (CNT_W + 1)'(1);
        sw_done   = (nxt >= lim);

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.idx = start_idx_i;
                    d.tmo = '0;
                    d.cnt = '0;
                    if (goal_off_i) begin
                        d.req[start_idx_i] = 1'b1;
                        d.st = S_DN_ACK;
                    end else if (IDLE_ONLY[start_idx_i]) begin
                        d.req[start_idx_i] = 1'b0;
                        d.st = S_UP_ACK;
                    end else begin
                        d.sw[start_idx_i] = 1'b0;
                        d.st = S_UP_SW;
                    end
                end
            end
            S_DN_ACK: begin
                if (ack_k) begin
                    d.st  = S_DN_IDL;
                    d.tmo = '0;
                end else if (tmo_hit) begin
                    err_set_o[q.idx] = 1'b1;
                    d.req[q.idx]     = 1'b0;
                    d.st             = S_IDLE;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            S_DN_IDL: begin
                if (idl_k) begin
                    if (only_k) begin
                        d.off[q.idx] = 1'b1;
                        d.st         = S_IDLE;
                    end else begin
                        d.sw[q.idx] = 1'b1;
                        d.cnt       = '0;
                        d.st        = S_DN_SW;
                    end
                end else if (tmo_hit) begin
                    err_set_o[q.idx] = 1'b1;
                    d.req[q.idx]     = 1'b0;
                    d.st             = S_IDLE;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            S_DN_SW: begin
                if (sw_done) begin
                    d.off[q.idx] = 1'b1;
                    d.st         = S_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_UP_SW: begin
                if (sw_done) begin
                    d.off[q.idx] = 1'b0;
                    d.st         = S_UP_REL;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_UP_REL: begin
                d.req[q.idx] = 1'b0;
                d.tmo        = '0;
                d.st         = S_UP_ACK;
            end
            S_UP_ACK: begin
                if (!ack_k) begin
                    d.st  = S_UP_IDL;
                    d.tmo = '0;
                end else if (tmo_hit) begin
                    err_set_o[q.idx] = 1'b1;
                    d.st             = S_IDLE;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
            default: begin
                if (!idl_k) begin
                    if (only_k) d.off[q.idx] = 1'b0;
                    d.st = S_IDLE;
                end else if (tmo_hit) begin
                    err_set_o[q.idx] = 1'b1;
                    d.st             = S_IDLE;
                end else begin
                    d.tmo = q.tmo + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.st != S_IDLE);
    assign off_o  = q.off;
    assign req_o  = q.req;
    assign sw_o   = q.sw;

    // R10: only one power domain between switch and status
    a_r10_one_window: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(q.sw ^ (q.off & ~IDLE_ONLY)));

    // R2: when no sequence runs, every switch agrees with its status
    a_r2_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> (((q.sw ^ q.off) & ~IDLE_ONLY) == '0));

    generate
        for (genvar g = 0; g < NDOM; g++) begin : g_chk
            // R3: switch opens only after request, ack and idle were all high
            a_r3_open_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(q.sw[g]) |-> $past(q.req[g] && ack_i[g] && idle_i[g]));
            // R5: a power domain's request falls only once it is on
            a_r5_release_after_on: assert property (@(posedge clk) disable iff (!rst_n)
                (!IDLE_ONLY[g] && $fell(q.req[g])) |-> (!q.off[g] && !q.sw[g]));
        end
    endgenerate

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pds_pkg::*;
#(
    parameter int              NDOM      = 4,
    parameter logic [NDOM-1:0] IDLE_ONLY = 4'b1000,
    parameter int              ACK_SPLIT = 0,
    parameter int              CNT_W     = 16,
    parameter int              DEF_CNT   = 24,
    parameter int              TMO_CYC   = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [2:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic [NDOM-1:0] pwr_sw_off,
    output logic [NDOM-1:0] idle_req,
    input  logic [NDOM-1:0] idle_ack,
    input  logic [NDOM-1:0] idle_sts
);

    localparam int IW = (NDOM > 1) ? $clog2(NDOM) : 1;

    logic [NDOM-1:0]  pwr_q, ireq_q, err_q, off, err_set, tgt, pend;
    logic [CNT_W-1:0] dn_lim, up_lim;
    logic             any, busy, start, goal_off;
    logic [IW-1:0]    pick;

    pds_regs #(
        .NDOM(NDOM), .IDLE_ONLY(IDLE_ONLY), .ACK_SPLIT(ACK_SPLIT),
        .CNT_W(CNT_W), .DEF_CNT(DEF_CNT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .rdata_o(reg_rdata), .off_i(off),
        .ack_i(idle_ack), .idle_i(idle_sts), .err_set_i(err_set),
        .pwr_o(pwr_q), .ireq_o(ireq_q), .dn_lim_o(dn_lim),
        .up_lim_o(up_lim), .err_o(err_q)
    );

    assign tgt   = (pwr_q & ~IDLE_ONLY) | (ireq_q & IDLE_ONLY);
    assign pend  = (tgt ^ off) & ~err_q;
    assign start = any & ~busy;
    assign goal_off = tgt[pick];

    pds_arb #(.NDOM(NDOM), .IW(IW)) u_arb (
        .pend_i(pend), .any_o(any), .idx_o(pick)
    );

    pds_seq #(
        .NDOM(NDOM), .IDLE_ONLY(IDLE_ONLY), .CNT_W(CNT_W),
        .TMO_CYC(TMO_CYC), .IW(IW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .start_idx_i(pick),
        .goal_off_i(goal_off), .dn_lim_i(dn_lim), .up_lim_i(up_lim),
        .ack_i(idle_ack), .idle_i(idle_sts), .busy_o(busy), .off_o(off),
        .req_o(idle_req), .sw_o(pwr_sw_off), .err_set_o(err_set)
    );

    generate
        for (genvar g = 0; g < NDOM; g++) begin : g_err
            // R9: raising an error leaves power where it was
            a_r9_err_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(err_q[g]) |-> ($stable(off[g]) && !pwr_sw_off[g]));
        end
    endgenerate

endmodule

// File: tb/tb_pwr_dom_seq.sv
module tb_pwr_dom_seq;
    import pds_pkg::*;

    localparam int NDOM = 4;
    localparam logic [NDOM-1:0] ONLY = 4'b1000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_we = 1'b0;
    logic [2:0]      reg_addr = A_STAT;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NDOM-1:0] pwr_sw_off, idle_req, idle_ack, idle_sts;
    logic [NDOM-1:0] r1, r2, stall;

    int nchk = 0, nerr = 0, cyc = 0;
    int exp_dn = 24, exp_up = 24;
    int exp_q[$];
    string tag_q[$];
    int sw_cyc[NDOM];

    always #10 clk = ~clk;

    pwr_dom_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwr_sw_off(pwr_sw_off),
        .idle_req(idle_req), .idle_ack(idle_ack), .idle_sts(idle_sts)
    );

    // bus-side idle logic model: ack follows request after three edges, idle one later
    initial begin
        r1 = '0; r2 = '0; idle_ack = '0; idle_sts = '0; stall = '0;
        forever begin
            @(posedge clk);
            r1       <= idle_req;
            r2       <= r1;
            idle_ack <= (r2 & ~stall) | (idle_ack & stall);
            idle_sts <= idle_ack;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int k, input int d, input int v, input string t);
        exp_q.push_back(k * 100 + d * 10 + v);
        tag_q.push_back(t);
    endtask

    // driver side: expected events for one domain transition
    task automatic pwr_ev(input int d, input bit off);
        if (off) begin
            push(1, d, 1, "R3 request");
            push(2, d, 1, "R3 switch open");
            push(3, d, 1, "R2 status off");
        end else begin
            push(2, d, 0, "R5 switch close");
            push(3, d, 0, "R2 status on");
            push(1, d, 0, "R5 request release");
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #2 v = reg_rdata;
        #1 reg_addr = A_STAT;
    endtask

    task automatic drain();
        for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge clk);
        chk(exp_q.size() == 0, "R10 expected events not all seen", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        repeat (5) @(negedge clk);
    endtask

    task automatic got(input int k, input int d, input int v);
        int code, e;
        string t;
        code = k * 100 + d * 10 + v;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected event", code, -1);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(e == code, t, code, e);
        end
        if (k == 2) sw_cyc[d] = cyc;
        if (k == 3 && !ONLY[d])
            chk((cyc - sw_cyc[d]) == (v ? exp_dn : exp_up), "R4 switch to status distance",
                cyc - sw_cyc[d], v ? exp_dn : exp_up);
    endtask

    // monitor: compares observed edges against the expected queue
    initial begin
        logic [NDOM-1:0] p_req, p_sw, p_st;
        bit first = 1'b1;
        p_req = '0; p_sw = '0; p_st = '0;
        wait (rst_n);
        forever begin
            @(posedge clk);
            #5;
            cyc++;
            if (first) begin
                p_req = idle_req; p_sw = pwr_sw_off; p_st = reg_rdata[NDOM-1:0];
                first = 1'b0;
            end else begin
                for (int d = 0; d < NDOM; d++) begin
                    if (idle_req[d] != p_req[d]) got(1, d, int'(idle_req[d]));
                    if (pwr_sw_off[d] != p_sw[d]) got(2, d, int'(pwr_sw_off[d]));
                    if (!reg_we && reg_addr == A_STAT && reg_rdata[d] != p_st[d])
                        got(3, d, int'(reg_rdata[d]));
                end
                p_req = idle_req;
                p_sw  = pwr_sw_off;
                if (!reg_we && reg_addr == A_STAT) p_st = reg_rdata[NDOM-1:0];
            end
        end
    end

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        finish_up();
    end

    initial begin
        logic [31:0] v;
        for (int d = 0; d < NDOM; d++) sw_cyc[d] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        rd(A_STAT, v);  chk(v == 0, "R1 status after reset", v, 0);
        rd(A_PWR, v);   chk(v == 0, "R1 power word after reset", v, 0);
        rd(A_DNCNT, v); chk(v == 24, "R1 down count default", v, 24);
        rd(A_UPCNT, v); chk(v == 24, "R1 up count default", v, 24);
        rd(A_ERR, v);   chk(v == 0, "R1 error word after reset", v, 0);
        chk(idle_req == 0 && pwr_sw_off == 0, "R1 outputs after reset",
            int'({idle_req, pwr_sw_off}), 0);

        // R2 R3 R4: power down domain 0 with default count
        pwr_ev(0, 1'b1);
        wr(A_PWR, 32'h1);
        drain();
        rd(A_STAT, v); chk(v[0] == 1'b1, "R2 domain 0 reads off", v, 1);
        // R7 shared layout: idle at bit 0, ack at bit 16
        rd(A_IDLE, v); chk(v[0] && v[16] && v[15:1] == 0, "R7 idle/ack view", v, 32'h10001);
        rd(A_ACK, v);  chk(v == 0, "R7 split ack view unused", v, 0);

        // R4 new counts, R5 power up domain 0
        wr(A_DNCNT, 32'd5);
        wr(A_UPCNT, 32'd9);
        exp_dn = 5; exp_up = 9;
        pwr_ev(0, 1'b0);
        wr(A_PWR, 32'h0);
        drain();
        rd(A_STAT, v); chk(v == 0, "R2 domain 0 back on", v, 0);

        // R10 two domains requested together: lowest index first
        pwr_ev(0, 1'b1);
        pwr_ev(2, 1'b1);
        wr(A_PWR, 32'h5);
        drain();
        rd(A_STAT, v); chk(v == 32'h5, "R10 both domains off", v, 5);
        pwr_ev(0, 1'b0);
        pwr_ev(2, 1'b0);
        wr(A_PWR, 32'h0);
        drain();

        // R8 redundant write
        wr(A_PWR, 32'h0);
        repeat (100) @(negedge clk);
        chk(idle_req == 0 && pwr_sw_off == 0, "R8 no sequence on same state",
            int'({idle_req, pwr_sw_off}), 0);

        // R6 idle-only domain 3
        wr(A_PWR, 32'h8);
        repeat (60) @(negedge clk);
        rd(A_PWR, v);  chk(v == 0, "R6 power bit of idle-only domain reads 0", v, 0);
        rd(A_STAT, v); chk(v == 0, "R6 power write has no effect", v, 0);
        push(1, 3, 1, "R6 idle-only request");
        push(3, 3, 1, "R6 idle-only status");
        wr(A_IREQ, 32'h9);
        drain();
        rd(A_STAT, v); chk(v == 32'h8, "R6 only domain 3 idled", v, 8);
        chk(pwr_sw_off == 0, "R6 switch stays closed", int'(pwr_sw_off), 0);
        push(1, 3, 0, "R6 idle-only release");
        push(3, 3, 0, "R6 idle-only status on");
        wr(A_IREQ, 32'h0);
        drain();

        // R9 timeout on domain 1
        stall = 4'b0010;
        push(1, 1, 1, "R9 request before timeout");
        push(1, 1, 0, "R9 request withdrawn");
        wr(A_PWR, 32'h2);
        drain();
        rd(A_ERR, v);  chk(v == 32'h2, "R9 error bit set", v, 2);
        rd(A_STAT, v); chk(v == 0, "R9 power unchanged", v, 0);
        stall = '0;
        repeat (80) @(negedge clk);
        chk(idle_req == 0, "R9 errored domain not retried", int'(idle_req), 0);
        // R4 count of zero behaves as one
        wr(A_DNCNT, 32'd0);
        exp_dn = 1;
        pwr_ev(1, 1'b1);
        wr(A_ERR, 32'h2);
        drain();
        rd(A_ERR, v);  chk(v == 0, "R9 error cleared", v, 0);
        rd(A_STAT, v); chk(v == 32'h2, "R9 retry powers domain 1 off", v, 2);
        pwr_ev(1, 1'b0);
        wr(A_PWR, 32'h0);
        drain();
        rd(A_STAT, v); chk(v == 0, "R2 all domains on at end", v, 0);

        finish_up();
    end

endmodule